// File: doc/BRIEF.md
# First-Come Lock Arbiter

This block hands one shared lock to a set of requesters and grants it in the exact order in which they asked. It works like a ticket queue at a counter. When a requester raises its acquire input, the block issues it a number taken from a dispensing counter. A second counter shows which number is currently being served. The requester whose number matches the serving counter receives the grant. When the holder pulses its release input, the serving counter steps forward by one and the next number in line is called.

Waiting requesters never modify shared state. Each one only compares its stored number against the serving counter, so the only update per hand-over is one increment of that counter. Both counters are W bits wide and wrap around. W must be large enough that every requester can hold a distinct number at the same time, so the comparison stays correct after a wrap. A release from any requester that is not the current holder changes nothing and raises a one-cycle error flag.

Top module: `ticket_lock_arb`

## Requirements
- R1: After reset, both counters are 0, no grant is asserted and the error flag is low.
- R2: An acquire pulse from a requester that holds no ticket is accepted. The requester receives the dispenser's current value, and the dispenser then advances by the number of tickets issued in that cycle.
- R3: When several idle requesters acquire in the same cycle, they receive consecutive tickets in ascending requester-index order. They are granted in that order.
- R4: At most one bit of the grant vector is high in any cycle.
- R5: Grants follow arrival order. The grant is registered: it rises on the clock edge after the clock edge at which the holder's ticket equals the serving counter. A requester that acquires while the lock is free therefore sees its grant two edges after its acquire is sampled.
- R6: A release pulse from the current holder advances the serving counter by one and clears that holder's grant on the same edge. The next requester in line is granted one edge later.
- R7: A release pulse from a requester that does not hold the grant leaves the grant vector and both counters unchanged. By default the error flag is high for exactly the cycle after that release is sampled.
- R8: An acquire pulse from a requester that already holds a ticket, whether it is waiting or granted, is ignored. It gets no second place in line.
- R9: Both counters wrap modulo 2^W. W must be at least ceil(log2(N+1)), and this is checked at elaboration. First-come order is kept across the wrap.
- R10: A granted requester keeps its grant in every cycle until it releases.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| acq_i | input | N | Per-requester acquire pulse |
| rel_i | input | N | Per-requester release pulse |
| grant_o | output | N | Per-requester lock grant, at most one high |
| err_o | output | 1 | Pulse flagging a release by a non-holder |

## Verification
The bench targets same-cycle acquires. A design that ordered them by anything other than requester index would grant out of sequence. It also covers a holder releasing while others wait: a design that left the grant registered for one extra cycle would show two grants high, or grant the next requester too early. Releases from waiting or idle requesters must raise the error flag and leave the line untouched. A design that advanced the serving counter on them would skip a waiter. Long runs push both counters through several wraps, so a width or wrap mistake shows up as a requester that is never granted.

// File: rtl/tkl_pkg.sv
package tkl_pkg;

   // Smallest counter width that lets n requesters hold distinct tickets at once.
   function automatic int tkl_min_width(input int n);
      return $clog2(n + 1);
   endfunction

endpackage

// File: rtl/tkl_dispenser.sv
module tkl_dispenser #(
   parameter int N = 4,
   parameter int W = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [N-1:0]   take_i,
   output logic [N*W-1:0] offer_o
);

   logic [W-1:0] next_q;
   logic [W-1:0] next_d;

   // Tickets are issued to the accepted acquires in ascending index order (R3).
   always_comb begin
      logic [W-1:0] run;
      run = next_q;
      for (int i = 0; i < N; i++) begin
         offer_o[i*W +: W] = run;
         run = run + W'(take_i[i]);
      end
      next_d = run;
   end

   // Wraps modulo 2^W by plain overflow (R9).
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) next_q <= '0;
      else        next_q <= next_d;
   end

   assert_idle_dispenser_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (take_i == '0) |=> $stable(next_q));

endmodule

// File: rtl/tkl_slot.sv
module tkl_slot #(
   parameter int W = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         acq_i,
   input  logic         rel_i,
   input  logic [W-1:0] serving_i,
   input  logic [W-1:0] offer_i,
   output logic         take_o,
   output logic         grant_o
);

   logic         has_tkt_q;
   logic [W-1:0] tkt_q;
   logic         grant_q;
   logic         rel_ok;
   logic         grant_d;

   // An acquire counts only when no ticket is held (R8).
   assign take_o  = acq_i & ~has_tkt_q;
   // Only the holder may release (R6).
   assign rel_ok  = rel_i & grant_q;
   // A match on the serving counter is registered into the grant (R5).
   assign grant_d = has_tkt_q & ~rel_ok & (tkt_q == serving_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         has_tkt_q <= 1'b0;
         tkt_q     <= '0;
         grant_q   <= 1'b0;
      end else begin
         grant_q <= grant_d;
         if (take_o) begin
            has_tkt_q <= 1'b1;
            tkt_q     <= offer_i;
         end else if (rel_ok) begin
            has_tkt_q <= 1'b0;
         end
      end
   end

   assign grant_o = grant_q;

   assert_grant_has_ticket_R5: assert property (@(posedge clk) disable iff (!rst_n)
      grant_q |-> has_tkt_q);

   assert_ticket_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (has_tkt_q && acq_i && !rel_ok) |=> (has_tkt_q && $stable(tkt_q)));

endmodule

// File: rtl/tkl_serving.sv
module tkl_serving #(
   parameter int N       = 4,
   parameter int W       = 3,
   parameter bit ERR_REG = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] rel_i,
   input  logic [N-1:0] grant_i,
   output logic [W-1:0] serving_o,
   output logic         err_o
);

   logic         advance;
   logic         bad_rel;
   logic [W-1:0] serving_q;

   assign advance = |(rel_i & grant_i);
   assign bad_rel = |(rel_i & ~grant_i);

   // Serving counter, wraps modulo 2^W (R6, R9).
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       serving_q <= '0;
      else if (advance) serving_q <= serving_q + 1'b1;
   end

   assign serving_o = serving_q;

   // Error flag: registered pulse (default) or same-cycle flag (R7).
   generate
      if (ERR_REG) begin : g_err_reg
         logic err_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) err_q <= 1'b0;
            else        err_q <= bad_rel;
         end
         assign err_o = err_q;
      end else begin : g_err_comb
         assign err_o = bad_rel;
      end
   endgenerate

   assert_serving_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !advance |=> $stable(serving_q));

endmodule

// File: rtl/ticket_lock_arb.sv
module ticket_lock_arb #(
   parameter int N       = 4,
   parameter int W       = 3,
   parameter bit ERR_REG = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] acq_i,
   input  logic [N-1:0] rel_i,
   output logic [N-1:0] grant_o,
   output logic         err_o
);
   import tkl_pkg::*;

   localparam int MIN_W = tkl_min_width(N);

   generate
      if (N < 1) begin : g_bad_n
         $error("ticket_lock_arb: N must be at least 1");
      end
      if (W < MIN_W) begin : g_bad_w
         $error("ticket_lock_arb: W too narrow for N requesters (R9)");
      end
   endgenerate

   logic [N-1:0]   take;
   logic [N-1:0]   grant;
   logic [N*W-1:0] offer;
   logic [W-1:0]   serving;

   tkl_dispenser #(.N(N), .W(W)) u_disp (
      .clk     (clk),
      .rst_n   (rst_n),
      .take_i  (take),
      .offer_o (offer)
   );

   generate
      for (genvar g = 0; g < N; g++) begin : g_slot
         tkl_slot #(.W(W)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .acq_i     (acq_i[g]),
            .rel_i     (rel_i[g]),
            .serving_i (serving),
            .offer_i   (offer[g*W +: W]),
            .take_o    (take[g]),
            .grant_o   (grant[g])
         );

         assert_grant_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (grant[g] && !rel_i[g]) |=> grant[g]);

         assert_release_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (grant[g] && rel_i[g]) |=> !grant[g]);
      end
   endgenerate

   tkl_serving #(.N(N), .W(W), .ERR_REG(ERR_REG)) u_srv (
      .clk       (clk),
      .rst_n     (rst_n),
      .rel_i     (rel_i),
      .grant_i   (grant),
      .serving_o (serving),
      .err_o     (err_o)
   );

   assign grant_o = grant;

   assert_single_holder_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   generate
      if (ERR_REG) begin : g_err_chk
         assert_bad_release_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
            ((rel_i & ~grant) != '0) |=> err_o);
         assert_good_release_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
            ((rel_i & ~grant) == '0) |=> !err_o);
      end
   endgenerate

endmodule

// File: tb/test_ticket_lock_arb.sv
module test_ticket_lock_arb;

   localparam int N          = 4;
   localparam int W          = 3;
   localparam int CLK_PERIOD = 10;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] acq = '0;
   logic [N-1:0] rel = '0;
   logic [N-1:0] grant;
   logic         err;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   // Reference model: queue of requester indices in ticket order.
   int           q[$];
   logic [N-1:0] exp_grant = '0;
   logic         exp_err   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ticket_lock_arb #(.N(N), .W(W)) i_ticket_lock_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .acq_i   (acq),
      .rel_i   (rel),
      .grant_o (grant),
      .err_o   (err)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step(input logic [N-1:0] a, input logic [N-1:0] r, input string tag);
      logic [N-1:0] nxt_grant;
      logic         nxt_err;
      logic [N-1:0] inq;
      acq = a;
      rel = r;
      @(posedge clk);
      nxt_grant = '0;
      if (q.size() > 0 && !(r[q[0]] && exp_grant[q[0]])) nxt_grant[q[0]] = 1'b1;
      nxt_err = |(r & ~exp_grant);
      inq = '0;
      foreach (q[k]) inq[q[k]] = 1'b1;
      if ((r & exp_grant) != '0) void'(q.pop_front());
      for (int i = 0; i < N; i++) if (a[i] && !inq[i]) q.push_back(i);
      exp_grant = nxt_grant;
      exp_err   = nxt_err;
      @(negedge clk);
      check(grant == exp_grant, {tag, " grant"}, int'(grant), int'(exp_grant));
      check(err == exp_err, {tag, " err"}, int'(err), int'(exp_err));
   endtask

   task automatic idle(input int n, input string tag);
      for (int i = 0; i < n; i++) step('0, '0, tag);
   endtask

   initial begin
      logic [15:0] lf;
      repeat (3) @(negedge clk);
      // R1: reset state
      check(grant == '0, "R1 grant", int'(grant), 0);
      check(err == 1'b0, "R1 err", int'(err), 0);
      rst_n = 1'b1;
      idle(2, "R1 idle");

      // R2/R5: lone acquire, grant two edges later; R10 hold; R6 release
      step(4'b0010, '0, "R2 acquire");
      step('0, '0, "R5 latency");
      idle(3, "R10 hold");
      step('0, 4'b0010, "R6 release");
      idle(2, "R6 after");

      // R3: all four in one cycle, granted 0,1,2,3
      step(4'b1111, '0, "R3 burst");
      for (int i = 0; i < N; i++) begin
         idle(2, "R3 wait");
         step('0, 4'(1 << i), "R3 release");
      end
      idle(2, "R3 drain");

      // R5: staggered arrival 2, 0, 3
      step(4'b0100, '0, "R5 arrive2");
      step(4'b0001, '0, "R5 arrive0");
      step(4'b1000, '0, "R5 arrive3");
      idle(1, "R5 wait");
      // R7: waiter 0 and idle 1 release -> error, nothing moves
      step('0, 4'b0011, "R7 bad release");
      idle(2, "R7 after");
      // R8: holder 2 and waiter 3 re-acquire -> ignored
      step(4'b1100, '0, "R8 reacquire");
      step('0, 4'b0100, "R6 release2");
      idle(2, "R5 next0");
      step('0, 4'b0001, "R6 release0");
      idle(2, "R5 next3");
      step('0, 4'b1000, "R6 release3");
      idle(3, "R8 no extra grant");

      // R9: many tickets to wrap both counters, interleaving two requesters
      for (int i = 0; i < 12; i++) begin
         step(4'b0101, '0, "R9 pair");
         idle(1, "R9 wait");
         step('0, 4'b0001, "R9 rel0");
         idle(1, "R9 wait");
         step('0, 4'b0100, "R9 rel2");
      end
      idle(2, "R9 drain");

      // Mixed pseudo-random traffic, R4 checked via exact grant compare
      lf = 16'hACE1;
      for (int i = 0; i < 600; i++) begin
         logic [N-1:0] r;
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         r = lf[4] ? exp_grant : '0;
         if (lf[9:7] == 3'b000) r = r | 4'(1 << lf[6:5]);
         step(lf[3:0] & {lf[11], lf[12], lf[13], lf[14]}, r, "R4 mixed");
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule